// File: doc/BRIEF.md
# Nonvolatile Wiper Position Store and Restore Sequencer

This block sits between the wiper position register of a digitally stepped resistor and a slow nonvolatile memory cell. When the supply becomes valid, it fetches the saved setting and hands it to the position register. Until that load has happened the control interface is held locked, so no step, store or recall is accepted. A blank cell loads midscale. A value outside the legal range loads the top-scale step.

On a store request the sequencer captures the present position and issues a single write strobe. It then waits for the memory's done pulse. The lock stays asserted for the whole programming interval, which varies with conditions. A timeout bounds both the write wait and the read wait. A timeout sets a sticky error flag and releases the lock. A recall request repeats the power-up fetch. The memory port is a plain strobe, data and done handshake, so a behavioural model can stand in for the cell array.

Top module: `nvpos_seq`

## Requirements
- R1: While `rst` is high, `lock` is 1, and `pos_load`, `err_timeout`, `mem_rd` and `mem_wr` are 0.
- R2: Release of `rst` leads to exactly one `mem_rd` strobe, in the cycle after the first clock edge with `rst` low. `lock` stays 1 until the restore ends. `pos_load` pulses for one cycle, in the same cycle that `lock` falls. With a done arriving L cycles after the strobe is seen, `lock` is high for L+2 cycles after that first edge.
- R3: A read of the all-ones word of POS_W+1 bits means a blank cell, and loads midscale, 2^(POS_W-1).
- R4: A read word above 2^POS_W that is not all ones loads the top-scale value 2^POS_W. A word from 0 to 2^POS_W loads unchanged.
- R5: A store request accepted while unlocked yields exactly one single-cycle `mem_wr` strobe. `mem_wdata` carries the value of `pos_cur` at acceptance, and later changes of `pos_cur` do not alter it.
- R6: During a store, `lock` stays 1 from acceptance until the cycle after the done pulse is sampled: L+2 cycles for a memory latency L. No `pos_load` occurs.
- R7: Store and recall requests raised while `lock` is 1 are ignored. They cause no extra strobe and no change in the lock duration.
- R8: A recall request accepted while unlocked performs the same read, decode and load as at power-up.
- R9: When store and recall are requested in the same unlocked cycle, the store is taken and the recall is dropped.
- R10: A done pulse is accepted when it is sampled at most RD_TMO (read) or WR_TMO (write) cycles after the strobe cycle. Otherwise the wait ends at that count. A read timeout loads midscale. A write timeout leaves memory unwritten. Either timeout sets `err_timeout`, and the lock is released after TMO+1 cycles.
- R11: `err_timeout` stays 1 once set until `rst`, including across later successful operations.
- R12: A done pulse while unlocked is ignored. It produces no load and does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (supply not yet valid) |
| store_req | input | 1 | Request to save the current position |
| recall_req | input | 1 | Request to reload the position from memory |
| pos_cur | input | POS_W+1 | Present value of the position register |
| mem_rd | output | 1 | Single-cycle read strobe to memory |
| mem_wr | output | 1 | Single-cycle write strobe to memory |
| mem_wdata | output | POS_W+1 | Word to be programmed |
| mem_rdata | input | POS_W+1 | Word read from memory, valid with mem_done |
| mem_done | input | 1 | Memory completion pulse |
| lock | output | 1 | Control interface locked |
| pos_load | output | 1 | One-cycle load strobe for the position register |
| pos_load_val | output | POS_W+1 | Value to load into the position register |
| err_timeout | output | 1 | Sticky memory timeout flag |

## Verification
The bench runs a store and a recall for every legal position. It then pokes every out-of-range word and the blank word into the behavioural memory. A decoder that misclassified the blank word would load top scale instead of midscale, and a missing clamp would pass illegal positions through. Latencies are set at one below, exactly at and beyond each timeout. An off-by-one in the timeout comparison would either flag a good done as an error or accept a late one, and both show up in the lock length and the error flag. Requests are fired on every locked cycle, and `pos_cur` is changed right after a store is accepted. A sequencer that queued requests, or sampled the data late, would emit extra strobes or write the wrong word.

// File: rtl/nvpos_pkg.sv
package nvpos_pkg;

    typedef enum logic [2:0] {
        SQ_RESET        = 3'd0,
        SQ_RESTORE_READ = 3'd1,
        SQ_READY        = 3'd2,
        SQ_STORE_WRITE  = 3'd3,
        SQ_STORE_WAIT   = 3'd4
    } seq_state_e;

    // Bits needed to hold the values 0..n
    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/nvpos_timer.sv
module nvpos_timer #(
    parameter int unsigned MAXV = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   clr,
    output logic [nvpos_pkg::bits_for(MAXV+1)-1:0] cnt
);
    localparam int unsigned CW = nvpos_pkg::bits_for(MAXV + 1);

    // Saturating cycle counter; all-ones is above MAXV so a limit compare never wraps
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != {CW{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nvpos_decode.sv
module nvpos_decode #(
    parameter int unsigned POS_W = 7
) (
    input  logic [POS_W:0] raw,
    output logic [POS_W:0] pos
);
    localparam int unsigned    PW    = POS_W + 1;
    localparam logic [PW-1:0]  TOP   = {1'b1, {POS_W{1'b0}}};
    localparam logic [PW-1:0]  MID   = {2'b01, {(POS_W-1){1'b0}}};
    localparam logic [PW-1:0]  BLANK = {PW{1'b1}};

    always_comb begin
        if (raw == BLANK) begin
            pos = MID;
        end else if (raw > TOP) begin
            pos = TOP;
        end else begin
            pos = raw;
        end
    end
endmodule

// File: rtl/nvpos_seq.sv
module nvpos_seq
    import nvpos_pkg::*;
#(
    parameter int unsigned POS_W  = 7,
    parameter int unsigned RD_TMO = 2500,
    parameter int unsigned WR_TMO = 2500000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           store_req,
    input  logic           recall_req,
    input  logic [POS_W:0] pos_cur,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [POS_W:0] mem_wdata,
    input  logic [POS_W:0] mem_rdata,
    input  logic           mem_done,
    output logic           lock,
    output logic           pos_load,
    output logic [POS_W:0] pos_load_val,
    output logic           err_timeout
);
    localparam int unsigned   PW     = POS_W + 1;
    localparam int unsigned   TMAX   = (RD_TMO > WR_TMO) ? RD_TMO : WR_TMO;
    localparam int unsigned   CW     = bits_for(TMAX + 1);
    localparam logic [CW-1:0] RD_LIM = CW'(RD_TMO);
    localparam logic [CW-1:0] WR_LIM = CW'(WR_TMO);
    localparam logic [PW-1:0] MID    = {2'b01, {(POS_W-1){1'b0}}};

    seq_state_e    st, st_nx;
    logic [CW-1:0] cnt;
    logic          tmr_clr;
    logic [PW-1:0] wbuf;
    logic [PW-1:0] dec_pos;
    logic          rd_hit, rd_tmo, wr_hit, wr_tmo;
    logic          take_store, take_recall;

    // Counts cycles since the strobe of the current memory access
    assign tmr_clr = (st == SQ_READY) || (st == SQ_RESET);

    nvpos_timer #(.MAXV(TMAX)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (tmr_clr),
        .cnt (cnt)
    );

    nvpos_decode #(.POS_W(POS_W)) u_decode (
        .raw (mem_rdata),
        .pos (dec_pos)
    );

    always_comb begin
        take_store  = (st == SQ_READY) && store_req;
        take_recall = (st == SQ_READY) && !store_req && recall_req;
        rd_hit      = (st == SQ_RESTORE_READ) && (cnt != '0) && mem_done;
        rd_tmo      = (st == SQ_RESTORE_READ) && !rd_hit && (cnt == RD_LIM);
        wr_hit      = (st == SQ_STORE_WAIT) && mem_done;
        wr_tmo      = (st == SQ_STORE_WAIT) && !mem_done && (cnt == WR_LIM);
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_RESET:        st_nx = SQ_RESTORE_READ;
            SQ_RESTORE_READ: if (rd_hit || rd_tmo) st_nx = SQ_READY;
            SQ_READY: begin
                if (take_store)       st_nx = SQ_STORE_WRITE;
                else if (take_recall) st_nx = SQ_RESTORE_READ;
            end
            SQ_STORE_WRITE:  st_nx = SQ_STORE_WAIT;
            SQ_STORE_WAIT:   if (wr_hit || wr_tmo) st_nx = SQ_READY;
            default:         st_nx = SQ_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= SQ_RESET;
            pos_load     <= 1'b0;
            pos_load_val <= '0;
            wbuf         <= '0;
            err_timeout  <= 1'b0;
        end else begin
            st       <= st_nx;
            pos_load <= rd_hit || rd_tmo;
            if (rd_hit) begin
                pos_load_val <= dec_pos;
            end else if (rd_tmo) begin
                pos_load_val <= MID;
            end
            if (take_store) begin
                wbuf <= pos_cur;
            end
            if (rd_tmo || wr_tmo) begin
                err_timeout <= 1'b1;
            end
        end
    end

    assign lock      = (st != SQ_READY);
    assign mem_rd    = (st == SQ_RESTORE_READ) && (cnt == '0);
    assign mem_wr    = (st == SQ_STORE_WRITE);
    assign mem_wdata = wbuf;
endmodule

// File: rtl/nvpos_chk.sv
module nvpos_chk #(
    parameter int unsigned RD_TMO = 2500,
    parameter int unsigned WR_TMO = 2500000
) (
    input logic clk,
    input logic rst,
    input logic store_req,
    input logic recall_req,
    input logic mem_rd,
    input logic mem_wr,
    input logic lock,
    input logic pos_load,
    input logic err_timeout
);
    localparam int unsigned LIM = ((RD_TMO > WR_TMO) ? RD_TMO : WR_TMO) + 2;
    localparam int unsigned RW  = $clog2(LIM + 2) + 1;

    logic [RW-1:0] lock_run;

    always_ff @(posedge clk) begin
        if (rst || !lock) begin
            lock_run <= '0;
        end else if (lock_run != {RW{1'b1}}) begin
            lock_run <= lock_run + 1'b1;
        end
    end

    AST_RD_LOCKED: assert property (@(posedge clk) disable iff (rst) mem_rd |-> lock); // R2
    AST_LOAD_UNLOCKED: assert property (@(posedge clk) disable iff (rst) pos_load |-> !lock); // R2
    AST_WR_LOCKED: assert property (@(posedge clk) disable iff (rst) mem_wr |-> lock); // R6
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst) mem_wr |=> !mem_wr); // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) $onehot0({mem_rd, mem_wr})); // R5
    AST_STORE_FIRST: assert property (@(posedge clk) disable iff (rst) (!lock && store_req) |=> (mem_wr && !mem_rd)); // R9
    AST_RECALL_GO: assert property (@(posedge clk) disable iff (rst) (!lock && !store_req && recall_req) |=> mem_rd); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err_timeout |=> err_timeout); // R11
    AST_LOCK_BOUND: assert property (@(posedge clk) disable iff (rst) lock_run <= RW'(LIM)); // R10
endmodule

bind nvpos_seq nvpos_chk #(.RD_TMO(RD_TMO), .WR_TMO(WR_TMO)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .store_req   (store_req),
    .recall_req  (recall_req),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .lock        (lock),
    .pos_load    (pos_load),
    .err_timeout (err_timeout)
);

// File: tb/tb_nvpos_seq.sv
`timescale 1ns/1ps
module tb_nvpos_seq;
    localparam int POS_W  = 4;
    localparam int RD_TMO = 12;
    localparam int WR_TMO = 30;
    localparam int PW     = POS_W + 1;
    localparam int TOP    = 1 << POS_W;
    localparam int MID    = 1 << (POS_W - 1);
    localparam int BLANK  = (1 << PW) - 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1;
    logic          store_req = 1'b0, recall_req = 1'b0;
    logic [PW-1:0] pos_cur = '0;
    logic          mem_rd, mem_wr, mem_done, lock, pos_load, err_timeout;
    logic [PW-1:0] mem_wdata, pos_load_val;
    logic [PW-1:0] mem_rdata = '0;

    nvpos_seq #(.POS_W(POS_W), .RD_TMO(RD_TMO), .WR_TMO(WR_TMO)) dut (
        .clk(clk), .rst(rst), .store_req(store_req), .recall_req(recall_req),
        .pos_cur(pos_cur), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_done(mem_done), .lock(lock), .pos_load(pos_load),
        .pos_load_val(pos_load_val), .err_timeout(err_timeout)
    );

    // Behavioural memory: latency 0 means it never answers
    int            rd_lat = 1, wr_lat = 1, rcnt = 0, wcnt = 0;
    int            rd_strobes = 0, wr_strobes = 0;
    logic [PW-1:0] mem_word = BLANK[PW-1:0];
    logic [PW-1:0] wlatch = '0;
    logic          model_done = 1'b0, inj_done = 1'b0;
    assign mem_done = model_done | inj_done;

    always @(posedge clk) begin
        model_done <= 1'b0;
        if (rst) begin
            rcnt <= 0;
            wcnt <= 0;
        end else begin
            if (mem_rd) begin
                rcnt <= rd_lat;
                rd_strobes <= rd_strobes + 1;
            end else if (rcnt != 0) begin
                rcnt <= rcnt - 1;
                if (rcnt == 1) begin
                    model_done <= 1'b1;
                    mem_rdata  <= mem_word;
                end
            end
            if (mem_wr) begin
                wcnt <= wr_lat;
                wlatch <= mem_wdata;
                wr_strobes <= wr_strobes + 1;
            end else if (wcnt != 0) begin
                wcnt <= wcnt - 1;
                if (wcnt == 1) begin
                    model_done <= 1'b1;
                    mem_word   <= wlatch;
                end
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    bit exp_err = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int decode_exp(input int w);
        if (w == BLANK) return MID;
        if (w > TOP) return TOP;
        return w;
    endfunction

    function automatic bit lat_ok(input int lat, input int tmo);
        return (lat >= 1) && (lat + 1 <= tmo);
    endfunction

    // Counts locked negedges after the request edge; pokes requests while locked
    task automatic measure(input bit poke, input logic [PW-1:0] alt, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (!lock || n > 1000) begin
                store_req  = 1'b0;
                recall_req = 1'b0;
                break;
            end
            n++;
            pos_cur    = alt;
            store_req  = poke && n[0];
            recall_req = poke && !n[0];
        end
    endtask

    task automatic do_read(input bit is_reset, input int lat, input bit poke, input string req);
        int n, r0, w0, el, ev;
        bit ok;
        rd_lat = lat;
        r0 = rd_strobes;
        w0 = wr_strobes;
        ok = lat_ok(lat, RD_TMO);
        ev = ok ? decode_exp(int'(mem_word)) : MID;
        el = ok ? lat + 2 : RD_TMO + 1;
        if (!ok) exp_err = 1'b1;
        if (is_reset) rst = 1'b0;
        else recall_req = 1'b1;
        measure(poke, pos_cur, n);
        check({req, " lock cycles"}, n, el);
        check({req, " load pulse"}, int'(pos_load), 1);
        check({req, " load value"}, int'(pos_load_val), ev);
        check({req, " error flag R11"}, int'(err_timeout), int'(exp_err));
        check({req, " read strobes"}, rd_strobes - r0, 1);
        check({req, " write strobes"}, wr_strobes - w0, 0);
        @(negedge clk);
        check({req, " single load pulse R2"}, int'(pos_load), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_store(input int val, input int lat, input bit poke, input bit also_recall,
                            input string req);
        int n, r0, w0, el, old;
        bit ok;
        wr_lat = lat;
        r0 = rd_strobes;
        w0 = wr_strobes;
        old = int'(mem_word);
        ok = lat_ok(lat, WR_TMO);
        el = ok ? lat + 2 : WR_TMO + 1;
        if (!ok) exp_err = 1'b1;
        pos_cur    = PW'(val);
        store_req  = 1'b1;
        recall_req = also_recall;
        measure(poke, PW'(val) ^ PW'(5), n);
        check({req, " lock cycles R6"}, n, el);
        check({req, " no load R6"}, int'(pos_load), 0);
        check({req, " stored word R5"}, int'(mem_word), ok ? val : old);
        check({req, " error flag R11"}, int'(err_timeout), int'(exp_err));
        check({req, " write strobes R7"}, wr_strobes - w0, 1);
        check({req, " read strobes R7"}, rd_strobes - r0, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic hold_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 lock in reset", int'(lock), 1);
        check("R1 load in reset", int'(pos_load), 0);
        check("R1 error in reset", int'(err_timeout), 0);
        check("R1 strobes in reset", int'(mem_rd) + int'(mem_wr), 0);
        exp_err = 1'b0;
    endtask

    initial begin
        // Power-up from a blank cell
        hold_reset();
        do_read(1'b1, 3, 1'b0, "R2 R3 power-up blank");

        // Every legal position: store, then recall
        for (int v = 0; v <= TOP; v++) begin
            do_store(v, 1 + v % 5, 1'b0, 1'b0, "R5 store sweep");
            do_read(1'b0, 1 + v % 4, 1'b0, "R8 recall sweep");
        end

        // Out-of-range and blank words
        for (int w = TOP + 1; w <= BLANK; w++) begin
            mem_word = PW'(w);
            do_read(1'b0, 2, 1'b0, "R4 R3 decode sweep");
        end

        // Requests while locked are dropped
        do_store(9, 10, 1'b1, 1'b0, "R7 store poked");
        do_read(1'b0, 7, 1'b1, "R7 recall poked");

        // Store wins over a simultaneous recall
        do_store(3, 2, 1'b0, 1'b1, "R9 priority");

        // Timeout boundaries
        do_read(1'b0, RD_TMO - 1, 1'b0, "R10 read last ok");
        do_store(11, WR_TMO - 1, 1'b0, 1'b0, "R10 write last ok");
        check("R10 no error at boundary", int'(err_timeout), 0);
        do_store(6, 0, 1'b0, 1'b0, "R10 write timeout");
        check("R10 error after write timeout", int'(err_timeout), 1);
        do_read(1'b0, 4, 1'b0, "R11 sticky after good recall");
        do_read(1'b0, RD_TMO, 1'b0, "R10 read timeout");

        // Stray done while unlocked
        inj_done = 1'b1;
        @(negedge clk);
        inj_done = 1'b0;
        check("R12 stray done no lock", int'(lock), 0);
        check("R12 stray done no load", int'(pos_load), 0);
        @(negedge clk);
        check("R12 stray done still unlocked", int'(lock), 0);

        // Reset clears the flag; power-up restores the saved word
        hold_reset();
        check("R11 flag cleared by reset", int'(err_timeout), 0);
        do_read(1'b1, 5, 1'b0, "R2 power-up restore");
        hold_reset();
        do_read(1'b1, 0, 1'b0, "R10 power-up timeout");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule